// File: doc/BRIEF.md
# Card Clock Divider with Settle Flag

This block derives the clock driven to a memory card from the controller's source clock. Software writes a two-bit mode value and a twelve-bit divider value. Mode 1 sends the source clock straight to the card pin. Every other mode value uses a counter divider. A divider value of zero halves the source frequency. A nonzero value N slows the source by a factor of 4·N. Each divided mode keeps a 50% duty cycle.

A written setting does not take effect at once. It waits for the next falling edge of the card clock, or for the next source edge when the clock is in pass-through mode. The new divided clock then starts in its low phase, so the card never sees a shortened high pulse. A settle flag drops on the edge that captures a changed setting. It rises again only after the new clock has run two full periods, so software polls this flag before it talks to the card. Writing the setting that is already in force does nothing.

Top module: `card_clk_div`

## Requirements
- R1: With mode value 1 in force, `card_clk_o` follows `clk_i`: it is low in the low half of every source cycle and high in the high half.
- R2: With a mode value other than 1 and a divider of 0, the card clock period is 2 source cycles, and it is high for 1 of them.
- R3: With a mode value other than 1 and a divider N ≥ 1, the card clock period is 4·N source cycles, and it is high for 2·N of them.
- R4: Mode values 0, 2 and 3 all select the divider path. Mode value 2 with a divider of 2 gives a period of 8 cycles.
- R5: A write (`cfg_we_i` high at a rising `clk_i` edge) whose mode or divider differs from the last accepted setting makes `clk_stable_o` low right after that edge.
- R6: A changed setting takes effect at the first falling edge of the card clock after the write edge. When the old mode is pass-through, it takes effect at the next source edge. The new divided clock begins in its low phase.
- R7: `clk_stable_o` goes high at the edge that ends the second full period of the new clock. That is 4·H source edges after the apply edge for half-period H (H = 1 for divider 0, H = 2·N otherwise), or 2 edges after it in pass-through. It stays low until then.
- R8: A write that equals the last accepted setting is ignored. `clk_stable_o` stays high and the card clock period is unchanged.
- R9: A second changed write that arrives before the first one takes effect replaces it. Only the latest setting is applied.
- R10: During reset `card_clk_o` and `clk_stable_o` are low. After reset the block runs mode 0 with divider 4095. The settle flag rises at source edge 32760 after reset release, and the period is 16380 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low reset, synchronous to clk_i |
| cfg_we_i | input | 1 | Write strobe for the mode and divider fields |
| cfg_mode_i | input | 2 | Mode field; value 1 selects pass-through |
| cfg_div_i | input | 12 | Divider field |
| card_clk_o | output | 1 | Clock to the card |
| clk_stable_o | output | 1 | High once the current setting has run two full periods |

## Verification
The settle flag must be low at the negedge that follows the write edge W. The apply edge is found at the ports: it is the first falling edge of `card_clk_o` seen after W, or W+1 when leaving pass-through. From that edge the bench computes when the flag must rise: 4·H edges later, or 2 edges later in pass-through. It checks the flag low on every negedge before that cycle and high on that exact cycle. Periods and high times are measured between card-clock edges sampled one time unit after each negedge, and pass-through is checked just after both source edges.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
    localparam int unsigned MODE_W = 2;
    localparam int unsigned DIV_W  = 12;
    localparam int unsigned HALF_W = DIV_W + 1;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DIV_W-1:0]  div;
    } ccd_cfg_t;

    localparam ccd_cfg_t CFG_AT_RESET = '{mode: '0, div: '1};

    // Source cycles per card-clock half period
    function automatic logic [HALF_W-1:0] half_cycles(input logic [DIV_W-1:0] d);
        return (d == '0) ? HALF_W'(1) : {d, 1'b0};
    endfunction
endpackage

// File: rtl/ccd_cfg_track.sv
module ccd_cfg_track
    import ccd_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     we_i,
    input  ccd_cfg_t wcfg_i,
    input  logic     apply_i,
    output ccd_cfg_t tgt_o,
    output logic     pend_o,
    output logic     change_o
);
    typedef struct packed {
        ccd_cfg_t tgt;
        logic     pend;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d    = trk_q;
        change_o = we_i && (wcfg_i != trk_q.tgt);
        if (change_o) begin
            trk_d.tgt  = wcfg_i;
            trk_d.pend = 1'b1;
        end else if (apply_i) begin
            trk_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) trk_q <= '{tgt: CFG_AT_RESET, pend: 1'b0};
        else         trk_q <= trk_d;
    end

    assign tgt_o  = trk_q.tgt;
    assign pend_o = trk_q.pend;
endmodule

// File: rtl/ccd_clk_gen.sv
module ccd_clk_gen
    import ccd_pkg::*;
#(
    parameter int unsigned BYPASS_CODE = 1
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     pend_i,
    input  ccd_cfg_t tgt_i,
    output logic     apply_o,
    output logic     tick_o,
    output logic     bypass_o,
    output logic     div_clk_o
);
    typedef struct packed {
        ccd_cfg_t          act;
        logic [HALF_W-1:0] cnt;
        logic              clk;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [HALF_W-1:0] half;
    logic last, fall, bypass;

    always_comb begin
        bypass  = (gen_q.act.mode == MODE_W'(BYPASS_CODE));
        half    = half_cycles(gen_q.act.div);
        last    = (gen_q.cnt == half - 1'b1);
        fall    = !bypass && last && gen_q.clk;
        apply_o = pend_i && (bypass || fall);
        tick_o  = bypass || fall;
        gen_d   = gen_q;
        if (apply_o) begin
            gen_d.act = tgt_i;
            gen_d.cnt = '0;
            gen_d.clk = 1'b0;
        end else if (bypass) begin
            gen_d.cnt = '0;
            gen_d.clk = 1'b0;
        end else if (last) begin
            gen_d.cnt = '0;
            gen_d.clk = !gen_q.clk;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) gen_q <= '{act: CFG_AT_RESET, cnt: '0, clk: 1'b0};
        else         gen_q <= gen_d;
    end

    assign bypass_o  = bypass;
    assign div_clk_o = gen_q.clk;

    // R2 R3
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bypass |-> (gen_q.cnt < half));
endmodule

// File: rtl/ccd_settle.sv
module ccd_settle #(
    parameter int unsigned SETTLE_PERIODS = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic change_i,
    input  logic apply_i,
    input  logic pend_i,
    input  logic tick_i,
    output logic stable_o
);
    localparam int unsigned CW = $clog2(SETTLE_PERIODS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          stable;
    } stl_t;

    stl_t stl_d, stl_q;

    always_comb begin
        stl_d = stl_q;
        if (change_i) begin
            stl_d.stable = 1'b0;
            stl_d.cnt    = '0;
        end else if (apply_i) begin
            stl_d.cnt = '0;
        end else if (!pend_i && !stl_q.stable && tick_i) begin
            if (stl_q.cnt == CW'(SETTLE_PERIODS - 1)) begin
                stl_d.stable = 1'b1;
                stl_d.cnt    = '0;
            end else begin
                stl_d.cnt = stl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) stl_q <= '{cnt: '0, stable: 1'b0};
        else         stl_q <= stl_d;
    end

    assign stable_o = stl_q.stable;

    // R5
    stable_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stl_q.stable |-> !pend_i);
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import ccd_pkg::*;
#(
    parameter int unsigned BYPASS_CODE    = 1,
    parameter int unsigned SETTLE_PERIODS = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [MODE_W-1:0] cfg_mode_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    output logic              card_clk_o,
    output logic              clk_stable_o
);
    ccd_cfg_t wcfg, tgt;
    logic pend, change, apply, tick, bypass, div_clk;

    assign wcfg = '{mode: cfg_mode_i, div: cfg_div_i};

    ccd_cfg_track u_track (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (cfg_we_i),
        .wcfg_i   (wcfg),
        .apply_i  (apply),
        .tgt_o    (tgt),
        .pend_o   (pend),
        .change_o (change)
    );

    ccd_clk_gen #(.BYPASS_CODE(BYPASS_CODE)) u_gen (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pend_i    (pend),
        .tgt_i     (tgt),
        .apply_o   (apply),
        .tick_o    (tick),
        .bypass_o  (bypass),
        .div_clk_o (div_clk)
    );

    ccd_settle #(.SETTLE_PERIODS(SETTLE_PERIODS)) u_settle (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .change_i (change),
        .apply_i  (apply),
        .pend_i   (pend),
        .tick_i   (tick),
        .stable_o (clk_stable_o)
    );

    assign card_clk_o = bypass ? clk_i : div_clk;

    // R5
    stable_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        change |=> !clk_stable_o);

    // R7
    rise_nopend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_stable_o) |-> !pend);

    // R6
    apply_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (apply && !bypass) |-> div_clk);
endmodule

// File: tb/tb_card_clk_div.sv
module tb_card_clk_div;
    timeunit 1ns;
    timeprecision 1ps;
    import ccd_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0;
    logic [MODE_W-1:0] mode = '0;
    logic [DIV_W-1:0]  div = '0;
    logic card_clk, stable;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit cur_byp = 1'b0;
    bit saw_low = 1'b0;

    typedef struct {
        int    m;
        int    d;
        int    w;
        bit    oldbyp;
        bit    same;
        int    ea_fixed;
        string req;
    } item_t;

    item_t q[$];

    card_clk_div dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_we_i     (we),
        .cfg_mode_i   (mode),
        .cfg_div_i    (div),
        .card_clk_o   (card_clk),
        .clk_stable_o (stable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int halfp(input int d);
        return (d == 0) ? 1 : 2 * d;
    endfunction

    // wait for a card-clock edge (rising or falling), sampled after negedges
    task automatic wait_edge(input bit rising, output int t);
        logic pc;
        pc = card_clk;
        t = -1;
        while (t < 0) begin
            @(negedge clk); #1;
            if (!stable) saw_low = 1'b1;
            if (rising && !pc && card_clk) t = cyc;
            if (!rising && pc && !card_clk) t = cyc;
            pc = card_clk;
        end
    endtask

    // driver
    task automatic write_cfg(input int m, input int d, input string req,
                             input bit same, input bit push);
        int w;
        @(negedge clk);
        we = 1'b1; mode = MODE_W'(m); div = DIV_W'(d);
        @(negedge clk); #1;
        we = 1'b0;
        w = cyc;
        if (same) chk({req, " stable held at write"}, int'(stable), 1);
        else      chk({req, " R5 stable drops after write"}, int'(stable), 0);
        if (push) begin
            q.push_back('{m, d, w, cur_byp, same, -1, req});
            wait (q.size() == 0);
            cur_byp = (m == 1);
        end
    endtask

    // monitor
    initial begin
        forever begin
            item_t it;
            int ea, er, h, t1, t2, t3;
            bit byp, early;
            wait (q.size() != 0);
            it = q[0];
            byp = (it.m == 1);
            h = halfp(it.d);
            if (!it.same) begin
                if (it.ea_fixed >= 0) ea = it.ea_fixed;
                else if (it.oldbyp) ea = it.w + 1;
                else wait_edge(1'b0, ea);
                er = ea + (byp ? 2 : 4 * h);
                early = 1'b0;
                while (cyc < er) begin
                    @(negedge clk); #1;
                    if (cyc < er && stable) early = 1'b1;
                end
                chk({it.req, " R7 stable low before two periods"}, int'(early), 0);
                chk({it.req, " R7 stable rises on time"}, int'(stable), 1);
            end
            saw_low = 1'b0;
            if (byp) begin
                repeat (3) begin
                    @(negedge clk); #1;
                    chk({it.req, " R1 bypass low half"}, int'(card_clk), 0);
                    @(posedge clk); #1;
                    chk({it.req, " R1 bypass high half"}, int'(card_clk), 1);
                end
            end else begin
                wait_edge(1'b1, t1);
                wait_edge(1'b0, t2);
                wait_edge(1'b1, t3);
                chk({it.req, " period"}, t3 - t1, 2 * h);
                chk({it.req, " high time"}, t2 - t1, h);
            end
            if (it.same) chk({it.req, " R8 stable never dropped"}, int'(saw_low), 0);
            void'(q.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10 card clock low in reset", int'(card_clk), 0);
        chk("R10 stable low in reset", int'(stable), 0);
        rst_n = 1'b1;
        q.push_back('{0, 4095, 0, 1'b0, 1'b0, 0, "R10"});
        wait (q.size() == 0);
        write_cfg(0, 0, "R2", 1'b0, 1'b1);
        write_cfg(0, 3, "R3", 1'b0, 1'b1);
        write_cfg(1, 7, "R1", 1'b0, 1'b1);
        write_cfg(0, 1, "R6", 1'b0, 1'b1);
        write_cfg(0, 1, "R8", 1'b1, 1'b1);
        write_cfg(2, 2, "R4", 1'b0, 1'b1);
        write_cfg(0, 5, "R9 first", 1'b0, 1'b0);
        write_cfg(0, 4, "R9", 1'b0, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule